// File: doc/BRIEF.md
# Differential Dual-Counter Frequency TDC

This block turns two free-running oscillator clocks into one signed number. While a measurement window is open it counts rising edges of each oscillator in that oscillator's own clock domain. When the window closes it waits a fixed number of system cycles, takes both frozen counts into the system clock domain and outputs the P count minus the N count as a two's-complement word. The result is zero when both oscillators run at the same rate. It is positive when the P oscillator is faster and negative when the N oscillator is faster. A completion flag tells the consumer when the word may be read.

The window is framed by two strobes, `win_start` and `win_end`. Both are synchronous to `clk` and act on their rising edges. The window gate is passed into each oscillator domain through a two-stage synchronizer, and each counter clears when it sees the gate open. The counters saturate at all-ones and do not wrap. Both oscillators must keep running while a conversion is in progress. Each oscillator period must be short enough that three of its edges fit inside the settle delay.

Top module: `freq_diff_tdc`

## Requirements
- R1: While reset is asserted, and after it is released, `conv_done` is 0 and `diff_o` is 0 until the first conversion completes.
- R2: After a window, `diff_o` equals the P edge count minus the N edge count taken inside the window. Because each boundary is resolved in the oscillator's own domain, the result may be up to 3 away from the difference of the ideal counts.
- R3: `diff_o` is two's complement, `CNT_W+1` bits wide. It is positive when the P oscillator is faster and negative when the N oscillator is faster. It is exactly 0 when both inputs carry the same clock.
- R4: `conv_done` rises exactly `SETTLE_CYC` clock cycles after the edge that samples the rising edge of `win_end`, and `diff_o` is updated at that same edge.
- R5: `conv_done` stays high, and `diff_o` stays unchanged, until the next rising edge of `win_start`. `conv_done` is low one cycle after that edge.
- R6: Each counter clears when a window opens, so a result depends only on its own window.
- R7: Each count stops at all-ones (2^CNT_W - 1) instead of wrapping. If both counts saturate, the result is 0.
- R8: A rising edge of `win_end` with no open window (idle, or after completion) is ignored: `conv_done` and `diff_o` keep their values.
- R9: If both strobes rise in the same cycle, only the one that is legal in the current state takes effect. While a window is open the end takes effect and the start is ignored. While idle or done the start takes effect and the end is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| osc_p | input | 1 | P oscillator clock (asynchronous) |
| osc_n | input | 1 | N oscillator clock (asynchronous) |
| win_start | input | 1 | Window-start strobe; acts on its rising edge |
| win_end | input | 1 | Window-end strobe; acts on its rising edge |
| diff_o | output | CNT_W+1 | Signed result, P count minus N count |
| conv_done | output | 1 | Conversion complete; `diff_o` is valid while high |

## Verification
Window-start and window-end can rise in the same system cycle, so that cycle decides whether a new window opens or the current one closes. The bench raises both strobes together at the same clock edge in two states. In the done state, `conv_done` must drop one cycle later, and a fresh result must follow a later window-end. While a window is open, `conv_done` must rise exactly the settle delay later with a result that matches the window that was closed.

// File: rtl/ftdc_pkg.sv
package ftdc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COUNT  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_DONE   = 2'd3
  } win_state_e;
endpackage

// File: rtl/ftdc_rst_sync.sv
module ftdc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/ftdc_edge_counter.sv
module ftdc_edge_counter #(
  parameter int CNT_W = 24
) (
  input  logic             osc,
  input  logic             rst_n,
  input  logic             gate_in,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0]       gsync_q;
  logic             gate_s;
  logic             gate_prev;
  logic             open_evt;
  logic             sat;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  // gate crosses into this oscillator domain; stage 2 is only an edge reference
  always_ff @(posedge osc or negedge rst_n) begin
    if (!rst_n) gsync_q <= 3'b000;
    else        gsync_q <= {gsync_q[1:0], gate_in};
  end

  assign gate_s    = gsync_q[1];
  assign gate_prev = gsync_q[2];
  assign open_evt  = gate_s & ~gate_prev;
  assign sat       = (cnt_q == CNT_MAX);
  assign cnt_en    = open_evt | (gate_s & ~sat);

  always_comb begin
    cnt_nxt = cnt_q;
    if (open_evt)    cnt_nxt = '0;
    else if (gate_s) cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge osc or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;

  // R7: a saturated count never wraps while the window stays open
  p_sat_hold_r7: assert property (@(posedge osc) disable iff (!rst_n)
    (sat && gate_s && !open_evt) |=> (cnt_q == CNT_MAX));

  // R2: no edge is counted while the synchronized gate is closed
  p_closed_frozen_r2: assert property (@(posedge osc) disable iff (!rst_n)
    (!gate_s) |=> $stable(cnt_q));

  // R6: opening the window restarts from zero
  p_clear_on_open_r6: assert property (@(posedge osc) disable iff (!rst_n)
    open_evt |=> (cnt_q == '0));
endmodule

// File: rtl/ftdc_window_ctrl.sv
module ftdc_window_ctrl
  import ftdc_pkg::*;
#(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic end_i,
  output logic gate_o,
  output logic cap_o,
  output logic done_o
);
  localparam int TW = $clog2(SETTLE_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(SETTLE_CYC - 1);

  win_state_e    state_q, state_nxt;
  logic [TW-1:0] tmr_q, tmr_nxt;
  logic          start_q, end_q;
  logic          start_rise, end_rise;
  logic          gate_q;

  assign start_rise = start_i & ~start_q;
  assign end_rise   = end_i & ~end_q;

  always_comb begin
    state_nxt = state_q;
    tmr_nxt   = tmr_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_rise) state_nxt = ST_COUNT;
      end
      ST_COUNT: begin
        if (end_rise) begin
          state_nxt = ST_SETTLE;
          tmr_nxt   = '0;
        end
      end
      ST_SETTLE: begin
        if (tmr_q == LAST) state_nxt = ST_DONE;
        else               tmr_nxt   = tmr_q + 1'b1;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      start_q <= 1'b0;
      end_q   <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      state_q <= state_nxt;
      tmr_q   <= tmr_nxt;
      start_q <= start_i;
      end_q   <= end_i;
      gate_q  <= (state_nxt == ST_COUNT);
    end
  end

  assign gate_o = gate_q;
  assign cap_o  = (state_q == ST_SETTLE) && (tmr_q == LAST);
  assign done_o = (state_q == ST_DONE);

  // R5: completion holds until a new window opens
  p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_rise) |=> done_o);

  // R5: a window-start while done drops the flag one cycle later
  p_done_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_rise) |=> (!done_o && gate_o));

  // R8: a stray window-end while idle changes nothing
  p_stray_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && end_rise && !start_rise) |=> (state_q == ST_IDLE));

  // R9: while open, an end closes the gate even if a start arrives with it
  p_end_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COUNT && end_rise) |=> !gate_o);
endmodule

// File: rtl/ftdc_diff_reg.sv
module ftdc_diff_reg #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] cnt_p_i,
  input  logic [CNT_W-1:0] cnt_n_i,
  output logic [CNT_W:0]   diff_o
);
  logic [CNT_W:0] diff_q, diff_nxt;

  // zero-extended operands: the CNT_W+1 result always fits in two's complement
  always_comb begin
    diff_nxt = {1'b0, cnt_p_i} - {1'b0, cnt_n_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     diff_q <= '0;
    else if (cap_i) diff_q <= diff_nxt;
  end

  assign diff_o = diff_q;

  // R5: the result only moves on a capture
  p_hold_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_i) |=> $stable(diff_q));
endmodule

// File: rtl/freq_diff_tdc.sv
module freq_diff_tdc #(
  parameter int CNT_W      = 24,
  parameter int SETTLE_CYC = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           osc_p,
  input  logic           osc_n,
  input  logic           win_start,
  input  logic           win_end,
  output logic [CNT_W:0] diff_o,
  output logic           conv_done
);
  logic             sys_rst_n;
  logic             gate;
  logic             cap;
  logic [1:0]       osc_v;
  logic [1:0]       osc_rst_n;
  logic [CNT_W-1:0] cnt_v [2];

  assign osc_v = {osc_n, osc_p};

  ftdc_rst_sync u_sys_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (sys_rst_n)
  );

  // one synchronizer-plus-counter lane per oscillator; lane 0 is P, lane 1 is N
  for (genvar gi = 0; gi < 2; gi++) begin : g_lane
    ftdc_rst_sync u_osc_rst (
      .clk    (osc_v[gi]),
      .arst_n (rst_n),
      .srst_n (osc_rst_n[gi])
    );
    ftdc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
      .osc     (osc_v[gi]),
      .rst_n   (osc_rst_n[gi]),
      .gate_in (gate),
      .cnt_o   (cnt_v[gi])
    );
  end

  ftdc_window_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .start_i (win_start),
    .end_i   (win_end),
    .gate_o  (gate),
    .cap_o   (cap),
    .done_o  (conv_done)
  );

  ftdc_diff_reg #(.CNT_W(CNT_W)) u_diff (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .cap_i   (cap),
    .cnt_p_i (cnt_v[0]),
    .cnt_n_i (cnt_v[1]),
    .diff_o  (diff_o)
  );

  // R4: the result capture and the completion flag land together
  p_done_after_cap_r4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    cap |=> conv_done);

  // R1: no completion is flagged while the gate is open
  p_no_done_open_r1: assert property (@(posedge clk) disable iff (!sys_rst_n)
    gate |-> !conv_done);
endmodule

// File: tb/freq_diff_tdc_tb_top.sv
`timescale 1ns/1ps
module freq_diff_tdc_tb_top;
  localparam int CNT_W  = 10;
  localparam int SETTLE = 12;
  localparam int MAXC   = (1 << CNT_W) - 1;
  localparam int NV     = 5;
  // {P period ns, N period ns, window cycles}
  localparam int VEC [NV][3] = '{
    '{10, 13, 400},
    '{13, 10, 400},
    '{9,  17, 600},
    '{16, 11, 250},
    '{7,  8,  150}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           osc_p = 1'b0;
  logic           osc_n_raw = 1'b0;
  logic           osc_n;
  logic           tie_n = 1'b0;
  logic           win_start = 1'b0;
  logic           win_end = 1'b0;
  logic [CNT_W:0] diff_o;
  logic           conv_done;

  real hp_p = 5.0;
  real hp_n = 6.5;
  int  ideal_p = 0;
  int  ideal_n = 0;
  bit  bench_win = 1'b0;
  int  n_cmp = 0;
  int  n_bad = 0;

  always #4 clk = ~clk;
  always #(hp_p) osc_p = ~osc_p;
  always #(hp_n) osc_n_raw = ~osc_n_raw;
  assign osc_n = tie_n ? osc_p : osc_n_raw;

  always @(posedge osc_p) if (bench_win) ideal_p++;
  always @(posedge osc_n) if (bench_win) ideal_n++;

  freq_diff_tdc #(.CNT_W(CNT_W), .SETTLE_CYC(SETTLE)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_p     (osc_p),
    .osc_n     (osc_n),
    .win_start (win_start),
    .win_end   (win_end),
    .diff_o    (diff_o),
    .conv_done (conv_done)
  );

  function automatic int sdiff();
    return int'($signed(diff_o));
  endfunction

  task automatic chk(input string req, input int act, input int exp, input int tol);
    n_cmp++;
    if (act > exp + tol || act < exp - tol) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", req, act, exp, tol);
    end
  endtask

  // start strobe (optionally with end in the same cycle); bench window opens at that edge
  task automatic open_win(input bit with_end);
    @(negedge clk);
    win_start = 1'b1;
    win_end   = with_end;
    @(posedge clk);
    ideal_p = 0;
    ideal_n = 0;
    bench_win = 1'b1;
    @(negedge clk);
    win_start = 1'b0;
    win_end   = 1'b0;
  endtask

  // end strobe (optionally with start), then checks the exact completion cycle
  task automatic close_win(input bit with_start, input string req);
    @(negedge clk);
    win_end   = 1'b1;
    win_start = with_start;
    @(posedge clk);
    bench_win = 1'b0;
    @(negedge clk);
    win_end   = 1'b0;
    win_start = 1'b0;
    repeat (SETTLE - 1) @(negedge clk);
    chk({req, " done still low one cycle early"}, int'(conv_done), 0, 0);
    @(negedge clk);
    chk({req, " done high after settle"}, int'(conv_done), 1, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int held;
    repeat (5) @(negedge clk);
    // R1: state held in reset
    chk("R1 done in reset", int'(conv_done), 0, 0);
    chk("R1 dout in reset", sdiff(), 0, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 done after reset", int'(conv_done), 0, 0);
    chk("R1 dout after reset", sdiff(), 0, 0);

    // R8: stray end while idle
    @(negedge clk); win_end = 1'b1;
    @(negedge clk); win_end = 1'b0;
    repeat (SETTLE + 4) @(negedge clk);
    chk("R8 idle stray end done", int'(conv_done), 0, 0);
    chk("R8 idle stray end dout", sdiff(), 0, 0);

    // R2 R3 R4 R6: vector table
    for (int v = 0; v < NV; v++) begin
      hp_p = VEC[v][0] / 2.0;
      hp_n = VEC[v][1] / 2.0;
      repeat (4) @(negedge clk);
      open_win(1'b0);
      repeat (VEC[v][2]) @(negedge clk);
      close_win(1'b0, "R4 table");
      chk("R2 R6 table result", sdiff(), ideal_p - ideal_n, 3);
      chk("R3 table sign", int'(sdiff() > 0), int'(VEC[v][0] < VEC[v][1]), 0);
    end

    // R5 R8: held result, stray end while done
    held = sdiff();
    repeat (50) @(negedge clk);
    chk("R5 done held", int'(conv_done), 1, 0);
    @(negedge clk); win_end = 1'b1;
    @(negedge clk); win_end = 1'b0;
    repeat (SETTLE + 4) @(negedge clk);
    chk("R8 done stray end flag", int'(conv_done), 1, 0);
    chk("R8 done stray end dout", sdiff(), held, 0);

    // R3: identical clocks give exactly zero
    tie_n = 1'b1;
    hp_p = 6.0;
    repeat (4) @(negedge clk);
    open_win(1'b0);
    chk("R5 done drops after start", int'(conv_done), 0, 0);
    repeat (300) @(negedge clk);
    close_win(1'b0, "R4 tied");
    chk("R3 tied clocks zero", sdiff(), 0, 0);
    tie_n = 1'b0;

    // R9: start and end together while done -> start wins
    hp_p = 5.5; hp_n = 9.0;
    repeat (4) @(negedge clk);
    open_win(1'b1);
    chk("R9 done state: start taken", int'(conv_done), 0, 0);
    repeat (200) @(negedge clk);
    chk("R9 done state: end ignored", int'(conv_done), 0, 0);
    // R9: start and end together while open -> end wins
    close_win(1'b1, "R9 open state");
    chk("R9 open state result", sdiff(), ideal_p - ideal_n, 3);
    repeat (SETTLE + 4) @(negedge clk);
    chk("R9 open state start ignored", int'(conv_done), 1, 0);

    // R7: P saturates, N does not
    hp_p = 3.5; hp_n = 10.0;
    repeat (4) @(negedge clk);
    open_win(1'b0);
    repeat (2000) @(negedge clk);
    close_win(1'b0, "R4 sat");
    chk("R7 P saturated", sdiff(), MAXC - ideal_n, 3);
    // R7: both saturate -> zero
    hp_n = 4.5;
    repeat (4) @(negedge clk);
    open_win(1'b0);
    repeat (2000) @(negedge clk);
    close_win(1'b0, "R4 sat both");
    chk("R7 both saturated", sdiff(), 0, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule